// File: doc/BRIEF.md
# Interrupt and Trap Delegation Register File

This block holds the machine-level interrupt-enable, interrupt-delegation, exception-delegation and trap-vector registers. It also holds the interrupt-pending word, whose supervisor software bits can be written and whose other bits come from hardware. A trap controller beside it reads the current values every cycle. Priority resolution and trap entry happen in that controller, not here.

Software reaches the registers through a register-access port. Each access names a register with a 3-bit select and supplies write data with a per-bit write mask. A bit set in the mask takes its new value from the write data. A clear bit keeps the old value. With this one form a plain write, a bit-set and a bit-clear all come from the same port. The read data shows the register's value before the access.

Two supervisor aliases show only the delegated interrupts. One is a view of the enable register and the other is a view of the pending word. Through these aliases the supervisor can change only the bits that the delegation register hands to it.

Top module: `trap_deleg_regs`

## Requirements
- R1: After a synchronous active-low reset the enable, interrupt-delegation, exception-delegation, trap-vector and pending outputs are all zero.
- R2: In the interrupt-enable register only bits 1, 3, 5, 7, 9 and 11 can be written. Every other bit reads zero.
- R3: In the interrupt-delegation register only bits 1, 5 and 9 can be written. Every other bit stays zero.
- R4: In the exception-delegation register bits 0 to 13 and bit 15 can be written. Bit 14 and all bits above 15 stay zero.
- R5: An access stores (old & ~wmask) | (wdata & wmask), subject to the per-register limits. An access with an all-zero mask changes nothing. `csr_rdata` shows the register's value before the access.
- R6: The supervisor enable view (select 5) reads as enable AND delegation. A write through it changes only the enable bits that are set in the delegation register.
- R7: Through the pending register (select 4), software can change only bit 1 (supervisor software) and bit 5 (supervisor timer). Through the supervisor pending view (select 6), those two bits can change only where they are also set in the delegation register. That view reads as pending AND delegation.
- R8: Pending bits 3, 7, 9 and 11 hold the machine-software, machine-timer, supervisor-external and machine-external inputs as sampled at the previous clock edge. Software writes never change them.
- R9: A trap-vector write whose merged value has bits [1:0] equal to 0 stores that value with bits [1:0] cleared. If bits [1:0] are anything else, the write is dropped and the old vector is kept.
- R10: The select codes are 0 enable, 1 interrupt delegation, 2 exception delegation, 3 trap vector, 4 pending, 5 supervisor enable and 6 supervisor pending. Code 7 reads zero and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_valid | input | 1 | Access strobe |
| csr_sel | input | 3 | Register select |
| csr_wdata | input | XLEN | Write data |
| csr_wmask | input | XLEN | Per-bit write mask |
| csr_rdata | output | XLEN | Value of the selected register before the access |
| hw_msip | input | 1 | Machine software interrupt source |
| hw_mtip | input | 1 | Machine timer interrupt source |
| hw_seip | input | 1 | Supervisor external interrupt source |
| hw_meip | input | 1 | Machine external interrupt source |
| ie_o | output | XLEN | Interrupt-enable register |
| ideleg_o | output | XLEN | Interrupt-delegation register |
| edeleg_o | output | XLEN | Exception-delegation register |
| tvec_o | output | XLEN | Trap-vector register |
| pend_o | output | XLEN | Interrupt-pending word |

## Verification
The bench writes a single one-hot bit to every position of each writable register, then a zero. This shows, bit by bit, which positions are writable and which are fixed at zero. Next it uses partial masks as bit-set and bit-clear accesses, which separates true read-modify-write merging from a plain overwrite. The supervisor views are driven under two different delegation patterns, so the tests can show whether a write leaks into bits that are not delegated. Trap-vector writes are tried with each of the four mode values. The hardware pending sources are toggled while software writes the pending word, which shows whether software can override a hardware-owned bit.

// File: rtl/tdeleg_pkg.sv
// Shared definitions for the trap delegation register file.
// Bit positions are those the trap controller decodes; they must not move.
package tdeleg_pkg;

    typedef enum logic [2:0] {
        SEL_IE     = 3'd0,
        SEL_IDELEG = 3'd1,
        SEL_EDELEG = 3'd2,
        SEL_TVEC   = 3'd3,
        SEL_PEND   = 3'd4,
        SEL_SIE    = 3'd5,
        SEL_SPEND  = 3'd6,
        SEL_NONE   = 3'd7
    } csr_sel_e;

    localparam int BIT_SSI = 1;
    localparam int BIT_MSI = 3;
    localparam int BIT_STI = 5;
    localparam int BIT_MTI = 7;
    localparam int BIT_SEI = 9;
    localparam int BIT_MEI = 11;

    // Writable exception causes: 0..15 except 14.
    function automatic logic [63:0] edeleg_mask64();
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < 16; i++) begin
            if (i != 14) m[i] = 1'b1;
        end
        return m;
    endfunction

    // Enable bits: the three supervisor and three machine interrupt lines.
    function automatic logic [63:0] ie_mask64();
        logic [63:0] m;
        m = '0;
        m[BIT_SSI] = 1'b1; m[BIT_MSI] = 1'b1; m[BIT_STI] = 1'b1;
        m[BIT_MTI] = 1'b1; m[BIT_SEI] = 1'b1; m[BIT_MEI] = 1'b1;
        return m;
    endfunction

    // Delegable interrupts: supervisor lines only.
    function automatic logic [63:0] ideleg_mask64();
        logic [63:0] m;
        m = '0;
        m[BIT_SSI] = 1'b1; m[BIT_STI] = 1'b1; m[BIT_SEI] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/tdeleg_masked_reg.sv
// Register with a fixed set of writable bits.
// Assumes: bits outside WMASK reset to zero and are never written, so they read zero.
module tdeleg_masked_reg #(
    parameter int              W     = 32,
    parameter logic [W-1:0]    WMASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wval,
    output logic [W-1:0] q
);

    // Update only the writable bits on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= (q & ~WMASK) | (wval & WMASK);
        end
    end

endmodule

// File: rtl/tdeleg_tvec.sv
// Trap-vector register accepting direct mode only.
// Assumes: wval is already merged with the old value; a nonzero mode field drops the write.
module tdeleg_tvec #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wval,
    output logic [W-1:0] q
);

    // Store the aligned base when the mode field is zero, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we && (wval[1:0] == 2'b00)) begin
            q <= {wval[W-1:2], 2'b00};
        end
    end

endmodule

// File: rtl/tdeleg_pending.sv
// Interrupt-pending word: two software bits and four sampled hardware lines.
// Assumes: the caller has already restricted sw_mask to the bits this access may touch.
module tdeleg_pending
    import tdeleg_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_we,
    input  logic [1:0]   sw_mask,   // [0] supervisor software, [1] supervisor timer
    input  logic [1:0]   sw_val,
    input  logic         hw_msip,
    input  logic         hw_mtip,
    input  logic         hw_seip,
    input  logic         hw_meip,
    output logic [W-1:0] pend
);

    logic ssip_q, stip_q;
    logic msip_q, mtip_q, seip_q, meip_q;

    // Software-owned bits: masked update on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ssip_q <= 1'b0;
            stip_q <= 1'b0;
        end else if (sw_we) begin
            if (sw_mask[0]) ssip_q <= sw_val[0];
            if (sw_mask[1]) stip_q <= sw_val[1];
        end
    end

    // Hardware-owned bits: resample the source lines every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msip_q <= 1'b0;
            mtip_q <= 1'b0;
            seip_q <= 1'b0;
            meip_q <= 1'b0;
        end else begin
            msip_q <= hw_msip;
            mtip_q <= hw_mtip;
            seip_q <= hw_seip;
            meip_q <= hw_meip;
        end
    end

    // Assemble the pending word at the decoded bit positions.
    always_comb begin
        pend          = '0;
        pend[BIT_SSI] = ssip_q;
        pend[BIT_MSI] = msip_q;
        pend[BIT_STI] = stip_q;
        pend[BIT_MTI] = mtip_q;
        pend[BIT_SEI] = seip_q;
        pend[BIT_MEI] = meip_q;
    end

endmodule

// File: rtl/trap_deleg_regs.sv
// Interrupt/trap delegation register file with supervisor aliases.
// Assumes: XLEN >= 16; one access per cycle; csr_rdata reflects state before the edge.
module trap_deleg_regs
    import tdeleg_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_valid,
    input  logic [2:0]      csr_sel,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic [XLEN-1:0] csr_wmask,
    output logic [XLEN-1:0] csr_rdata,
    input  logic            hw_msip,
    input  logic            hw_mtip,
    input  logic            hw_seip,
    input  logic            hw_meip,
    output logic [XLEN-1:0] ie_o,
    output logic [XLEN-1:0] ideleg_o,
    output logic [XLEN-1:0] edeleg_o,
    output logic [XLEN-1:0] tvec_o,
    output logic [XLEN-1:0] pend_o
);

    localparam logic [XLEN-1:0] IE_MASK     = XLEN'(ie_mask64());
    localparam logic [XLEN-1:0] IDELEG_MASK = XLEN'(ideleg_mask64());
    localparam logic [XLEN-1:0] EDELEG_MASK = XLEN'(edeleg_mask64());

    csr_sel_e        sel;
    logic            act;
    logic [XLEN-1:0] merged;
    logic [XLEN-1:0] ie_wval;
    logic [XLEN-1:0] pend_mask;
    logic            we_ie, we_id, we_ed, we_tv, we_pd;

    assign sel = csr_sel_e'(csr_sel);
    assign act = csr_valid && (|csr_wmask);

    // Read mux: value of the selected register before this access.
    always_comb begin
        unique case (sel)
            SEL_IE:     csr_rdata = ie_o;
            SEL_IDELEG: csr_rdata = ideleg_o;
            SEL_EDELEG: csr_rdata = edeleg_o;
            SEL_TVEC:   csr_rdata = tvec_o;
            SEL_PEND:   csr_rdata = pend_o;
            SEL_SIE:    csr_rdata = ie_o & ideleg_o;
            SEL_SPEND:  csr_rdata = pend_o & ideleg_o;
            default:    csr_rdata = '0;
        endcase
    end

    // Bitwise read-modify-write merge against the selected view.
    assign merged = (csr_rdata & ~csr_wmask) | (csr_wdata & csr_wmask);

    // Per-register write strobes and the enable write value for the alias.
    always_comb begin
        we_ie   = act && (sel == SEL_IE || sel == SEL_SIE);
        we_id   = act && (sel == SEL_IDELEG);
        we_ed   = act && (sel == SEL_EDELEG);
        we_tv   = act && (sel == SEL_TVEC);
        we_pd   = act && (sel == SEL_PEND || sel == SEL_SPEND);
        ie_wval = (sel == SEL_SIE) ? ((ie_o & ~ideleg_o) | (merged & ideleg_o)) : merged;
        pend_mask = (sel == SEL_SPEND) ? (csr_wmask & ideleg_o) : csr_wmask;
    end

    tdeleg_masked_reg #(.W(XLEN), .WMASK(IE_MASK)) u_ie (
        .clk(clk), .rst_n(rst_n), .we(we_ie), .wval(ie_wval), .q(ie_o)
    );

    tdeleg_masked_reg #(.W(XLEN), .WMASK(IDELEG_MASK)) u_ideleg (
        .clk(clk), .rst_n(rst_n), .we(we_id), .wval(merged), .q(ideleg_o)
    );

    tdeleg_masked_reg #(.W(XLEN), .WMASK(EDELEG_MASK)) u_edeleg (
        .clk(clk), .rst_n(rst_n), .we(we_ed), .wval(merged), .q(edeleg_o)
    );

    tdeleg_tvec #(.W(XLEN)) u_tvec (
        .clk(clk), .rst_n(rst_n), .we(we_tv), .wval(merged), .q(tvec_o)
    );

    tdeleg_pending #(.W(XLEN)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_we   (we_pd),
        .sw_mask ({pend_mask[BIT_STI], pend_mask[BIT_SSI]}),
        .sw_val  ({csr_wdata[BIT_STI], csr_wdata[BIT_SSI]}),
        .hw_msip (hw_msip),
        .hw_mtip (hw_mtip),
        .hw_seip (hw_seip),
        .hw_meip (hw_meip),
        .pend    (pend_o)
    );

endmodule

// File: rtl/tdeleg_checker.sv
// Temporal checks on the delegation register file, bound to the top module.
module tdeleg_checker
    import tdeleg_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            csr_valid,
    input logic [2:0]      csr_sel,
    input logic [XLEN-1:0] csr_wdata,
    input logic [XLEN-1:0] csr_wmask,
    input logic            hw_msip,
    input logic            hw_mtip,
    input logic            hw_seip,
    input logic            hw_meip,
    input logic [XLEN-1:0] ie_o,
    input logic [XLEN-1:0] ideleg_o,
    input logic [XLEN-1:0] edeleg_o,
    input logic [XLEN-1:0] tvec_o,
    input logic [XLEN-1:0] pend_o
);

    localparam logic [XLEN-1:0] IE_M = XLEN'(ie_mask64());
    localparam logic [XLEN-1:0] ID_M = XLEN'(ideleg_mask64());
    localparam logic [XLEN-1:0] ED_M = XLEN'(edeleg_mask64());

    // R1: one cycle after reset is applied, every register reads zero.
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (ie_o == '0 && ideleg_o == '0 && edeleg_o == '0 && tvec_o == '0));

    a_r2_ie_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ie_o & ~IE_M) == '0));

    a_r3_ideleg_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ideleg_o & ~ID_M) == '0));

    a_r4_edeleg_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((edeleg_o & ~ED_M) == '0));

    // R6: a supervisor-view write leaves non-delegated enable bits untouched.
    a_r6_sie_non_delegated: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && csr_sel == 3'd5)
        |=> ((ie_o & ~$past(ideleg_o)) == ($past(ie_o) & ~$past(ideleg_o))));

    a_r8_hw_lines_track: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_o[BIT_MSI] == $past(hw_msip) && pend_o[BIT_MTI] == $past(hw_mtip)
               && pend_o[BIT_SEI] == $past(hw_seip) && pend_o[BIT_MEI] == $past(hw_meip)));

    // R9: a full-mask vector write with a nonzero mode leaves the vector unchanged.
    a_r9_tvec_bad_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && csr_sel == 3'd3 && csr_wmask == '1 && csr_wdata[1:0] != 2'b00)
        |=> $stable(tvec_o));

    a_r10_unused_select: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && csr_sel == 3'd7)
        |=> ($stable(ie_o) && $stable(ideleg_o) && $stable(edeleg_o) && $stable(tvec_o)));

endmodule

bind trap_deleg_regs tdeleg_checker #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_wmask(csr_wmask),
    .hw_msip(hw_msip), .hw_mtip(hw_mtip), .hw_seip(hw_seip), .hw_meip(hw_meip),
    .ie_o(ie_o), .ideleg_o(ideleg_o), .edeleg_o(edeleg_o), .tvec_o(tvec_o), .pend_o(pend_o)
);

// File: tb/trap_deleg_regs_tb.sv
module trap_deleg_regs_tb;

    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            csr_valid = 1'b0;
    logic [2:0]      csr_sel = 3'd0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [XLEN-1:0] csr_wmask = '0;
    logic [XLEN-1:0] csr_rdata;
    logic            hw_msip = 1'b0, hw_mtip = 1'b0, hw_seip = 1'b0, hw_meip = 1'b0;
    logic [XLEN-1:0] ie_o, ideleg_o, edeleg_o, tvec_o, pend_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    trap_deleg_regs #(.XLEN(XLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_wmask(csr_wmask), .csr_rdata(csr_rdata),
        .hw_msip(hw_msip), .hw_mtip(hw_mtip), .hw_seip(hw_seip), .hw_meip(hw_meip),
        .ie_o(ie_o), .ideleg_o(ideleg_o), .edeleg_o(edeleg_o), .tvec_o(tvec_o), .pend_o(pend_o)
    );

    task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One access: drive at negedge, capture pre-edge read data, release at next negedge.
    task automatic access(input logic [2:0] sel, input logic [XLEN-1:0] wd,
                          input logic [XLEN-1:0] wm, output logic [XLEN-1:0] old);
        @(negedge clk);
        csr_valid = 1'b1; csr_sel = sel; csr_wdata = wd; csr_wmask = wm;
        #1 old = csr_rdata;
        @(negedge clk);
        csr_valid = 1'b0; csr_wmask = '0;
    endtask

    task automatic peek(input logic [2:0] sel, output logic [XLEN-1:0] v);
        csr_sel = sel;
        #1 v = csr_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [XLEN-1:0] old, v, m_ie, m_id, m_ed;
        m_ie = 32'h0000_0AAA;
        m_id = 32'h0000_0222;
        m_ed = 32'h0000_BFFF;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ie", ie_o, '0);
        check("R1 ideleg", ideleg_o, '0);
        check("R1 edeleg", edeleg_o, '0);
        check("R1 tvec", tvec_o, '0);
        check("R1 pend", pend_o, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4: one-hot sweep over every bit position
        for (int i = 0; i < XLEN; i++) begin
            logic [XLEN-1:0] oh;
            oh = 32'h1 << i;
            access(3'd0, oh, '1, old);
            check("R2 ie one-hot", ie_o, oh & m_ie);
            access(3'd1, oh, '1, old);
            check("R3 ideleg one-hot", ideleg_o, oh & m_id);
            access(3'd2, oh, '1, old);
            check("R4 edeleg one-hot", edeleg_o, oh & m_ed);
        end
        access(3'd0, '0, '1, old);
        access(3'd1, '0, '1, old);
        access(3'd2, '0, '1, old);
        check("R2 ie cleared", ie_o, '0);

        // R5: set, clear, read-only, old value return
        access(3'd2, '1, 32'h0000_00F0, old);
        check("R5 set returns old", old, '0);
        check("R5 set bits", edeleg_o, 32'h0000_00F0);
        access(3'd2, '0, 32'h0000_0030, old);
        check("R5 set old value", old, 32'h0000_00F0);
        check("R5 clear bits", edeleg_o, 32'h0000_00C0);
        access(3'd2, '1, '0, old);
        check("R5 zero mask no write", edeleg_o, 32'h0000_00C0);
        check("R5 zero mask reads", old, 32'h0000_00C0);

        // R6: supervisor enable view under two delegation patterns
        access(3'd0, 32'h0000_0088, '1, old);     // machine bits 3,7
        access(3'd1, 32'h0000_0222, '1, old);
        access(3'd5, '1, '1, old);
        check("R6 sie old read", old, '0);
        check("R6 sie sets delegated", ie_o, 32'h0000_02AA);
        peek(3'd5, v);
        check("R6 sie read masked", v, 32'h0000_0222);
        access(3'd1, 32'h0000_0020, '1, old);
        access(3'd5, '0, '1, old);
        check("R6 sie old under narrow deleg", old, 32'h0000_0020);
        check("R6 sie clears only delegated", ie_o, 32'h0000_028A);

        // R7: pending software bits through both views
        access(3'd4, '1, '1, old);
        check("R7 pend soft bits only", pend_o, 32'h0000_0022);
        access(3'd4, '0, 32'h0000_0002, old);
        check("R7 pend old value", old, 32'h0000_0022);
        check("R7 pend clear ssip", pend_o, 32'h0000_0020);
        access(3'd6, '0, '1, old);                  // deleg = bit 5 only
        check("R7 spend old masked", old, 32'h0000_0020);
        check("R7 spend clears stip", pend_o, 32'h0000_0000);
        access(3'd6, '1, '1, old);
        check("R7 spend cannot set ssip", pend_o, 32'h0000_0020);

        // R8: hardware lines, software cannot override
        @(negedge clk);
        hw_seip = 1'b1; hw_mtip = 1'b1;
        @(negedge clk);
        check("R8 hw lines sampled", pend_o, 32'h0000_02A0);
        access(3'd4, '0, '1, old);
        check("R8 seip survives write", pend_o, 32'h0000_0280);
        hw_seip = 1'b0; hw_mtip = 1'b0; hw_msip = 1'b1; hw_meip = 1'b1;
        @(negedge clk);
        check("R8 hw lines follow", pend_o, 32'h0000_0808);
        hw_msip = 1'b0; hw_meip = 1'b0;
        @(negedge clk);
        check("R8 hw lines drop", pend_o, '0);

        // R9: vector mode values
        access(3'd3, 32'h8000_1200, '1, old);
        check("R9 direct stored", tvec_o, 32'h8000_1200);
        for (int md = 1; md < 4; md++) begin
            access(3'd3, 32'h4000_0000 | md, '1, old);
            check("R9 non-direct ignored", tvec_o, 32'h8000_1200);
        end
        access(3'd3, 32'h0000_0004, 32'h0000_000F, old);
        check("R9 partial direct", tvec_o, 32'h8000_1204);

        // R10: unused select
        access(3'd7, '1, '1, old);
        check("R10 reads zero", old, '0);
        check("R10 ie unchanged", ie_o, 32'h0000_028A);
        check("R10 edeleg unchanged", edeleg_o, 32'h0000_00C0);
        check("R10 tvec unchanged", tvec_o, 32'h8000_1204);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule